// File: doc/BRIEF.md
# Addressed Framed-Message Receiver

This block sits behind a byte receiver on a shared multidrop command line. Each byte reaches it with a one-cycle valid strobe. The block follows the framing of every message on the line. A frame is a start character, an address byte, a command byte, zero or more data bytes, an end character and a one-byte longitudinal XOR check. The block keeps only the frames that carry its own address. Every other frame is dropped at the address byte, and the block then waits for the next start character.

While a frame for this node is arriving, the command and data bytes are stored in a small buffer and a running XOR is kept. When the trailing check byte comes in, the block gives a one-cycle good-message pulse, with the command, the data bytes and their count presented beside it. If the check byte does not match, it gives a one-cycle error pulse instead. Malformed frames are dropped without any report: a byte that is not printable, an empty body, or a body that is too long. The meaning of the command, any reply and control of the line are left to other logic.

Top module: `addr_msg_rx`

## Requirements
- R1: After reset is released, msg_valid and lrc_error are low and the receiver waits for a start character.
- R2: While waiting for a frame, any byte other than the start character 0x02 is ignored and produces no output.
- R3: The byte that follows the start character is compared with own_addr. On a match the body is received. On a mismatch the frame is dropped with neither msg_valid nor lrc_error, and the block waits for a new start character.
- R4: A start character 0x02 in the address position restarts the frame. The running check restarts at 0x02, and the next byte is taken as the address.
- R5: Body bytes (the command and the data) must be printable, 0x20 to 0x7E. Any other byte except the end character 0x03 drops the frame silently.
- R6: An end character with no body byte drops the frame silently. So does a body of more than 1+MAX_DATA bytes.
- R7: The check byte equals the XOR of the start character, the address, the command, every data byte and the end character. On a match, msg_valid is high for exactly one cycle, the cycle after the check byte is taken. In that cycle msg_cmd holds the command, data byte i sits at msg_data[8i+7:8i], and msg_len gives the number of data bytes.
- R8: On a check mismatch, lrc_error is high for one cycle, the cycle after the check byte, and msg_valid stays low.
- R9: After the check byte the receiver is idle again, so a frame that follows at once is received.
- R10: A byte presented while rx_valid is low has no effect on the framing, the check or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| own_addr | input | 8 | Address of this node |
| rx_valid | input | 1 | Byte strobe from the upstream receiver |
| rx_byte | input | 8 | Received byte |
| msg_valid | output | 1 | One-cycle pulse: a good message was received |
| msg_cmd | output | 8 | Command byte of the message |
| msg_data | output | 8*MAX_DATA | Data bytes, byte i at bits 8i+7:8i |
| msg_len | output | clog2(MAX_DATA+1) | Number of valid data bytes |
| lrc_error | output | 1 | One-cycle pulse: the check byte did not match |

## Verification
Most wrong internal states show up at the ports within one frame. A state register stuck in the wrong phase, or a slip in the byte counter, makes the next frame miss its good pulse, report a mismatch, or hand over a shifted or short payload. All of these appear in the cycle right after that frame's check byte. A running XOR that fails to restart or skips a byte turns a good frame into an error pulse at that same point. Random frames are sent with idle gaps between bytes and a mix of addresses, lengths and corrupted checks. Directed frames cover restarts, aborts and the length limits, so each such fault is exposed within a few frames.

// File: rtl/amr_pkg.sv
package amr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_BODY = 2'd2,
    ST_CHK  = 2'd3
  } amr_state_e;

  localparam logic [7:0] CH_START = 8'h02;
  localparam logic [7:0] CH_END   = 8'h03;
  localparam logic [7:0] PRINT_LO = 8'h20;
  localparam logic [7:0] PRINT_HI = 8'h7E;

  function automatic logic is_print(input logic [7:0] b);
    return (b >= PRINT_LO) && (b <= PRINT_HI);
  endfunction
endpackage

// File: rtl/amr_fsm.sv
module amr_fsm
  import amr_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [7:0]       own_addr,
  input  logic [CNT_W-1:0] body_cnt,
  input  logic [7:0]       lrc,
  output amr_state_e       state,
  output logic             frame_start,
  output logic             byte_acc,
  output logic             byte_cap,
  output logic             chk_pass,
  output logic             chk_fail
);
  localparam logic [CNT_W-1:0] BODY_MAX = CNT_W'(MAX_DATA + 1);

  amr_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    frame_start = 1'b0;
    byte_acc    = 1'b0;
    byte_cap    = 1'b0;
    chk_pass    = 1'b0;
    chk_fail    = 1'b0;
    if (rx_valid) begin
      unique case (state_q)
        ST_IDLE: begin
          if (rx_byte == CH_START) begin
            frame_start = 1'b1;
            state_d     = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (rx_byte == CH_START) begin
            frame_start = 1'b1;
            state_d     = ST_ADDR;
          end else if (rx_byte == own_addr) begin
            byte_acc = 1'b1;
            state_d  = ST_BODY;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_BODY: begin
          if (rx_byte == CH_END) begin
            byte_acc = 1'b1;
            state_d  = (body_cnt == '0) ? ST_IDLE : ST_CHK;
          end else if (is_print(rx_byte) && (body_cnt < BODY_MAX)) begin
            byte_acc = 1'b1;
            byte_cap = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_CHK: begin
          chk_pass = (rx_byte == lrc);
          chk_fail = (rx_byte != lrc);
          state_d  = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/amr_lrc.sv
module amr_lrc
  import amr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       byte_acc,
  input  logic [7:0] rx_byte,
  output logic [7:0] lrc
);
  logic [7:0] lrc_q, lrc_d;
  logic       lrc_en;

  assign lrc_en = frame_start | byte_acc;

  always_comb begin
    if (frame_start) lrc_d = CH_START;
    else             lrc_d = lrc_q ^ rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lrc_q <= '0;
    else if (lrc_en) lrc_q <= lrc_d;
  end

  assign lrc = lrc_q;
endmodule

// File: rtl/amr_buf.sv
module amr_buf #(
  parameter int MAX_DATA = 8,
  parameter int CNT_W    = 4,
  parameter int LEN_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  byte_cap,
  input  logic [7:0]            rx_byte,
  output logic [CNT_W-1:0]      body_cnt,
  output logic [7:0]            cmd,
  output logic [8*MAX_DATA-1:0] data,
  output logic [LEN_W-1:0]      len
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [7:0]       cmd_q;
  logic             cmd_en;

  assign cnt_en = frame_start | byte_cap;
  assign cnt_d  = frame_start ? '0 : cnt_q + 1'b1;
  assign cmd_en = byte_cap && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= rx_byte;
  end

  for (genvar i = 0; i < MAX_DATA; i++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_en;
    assign slot_en = byte_cap && (cnt_q == CNT_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= rx_byte;
    end
    assign data[8*i +: 8] = slot_q;
  end

  assign body_cnt = cnt_q;
  assign cmd      = cmd_q;
  assign len      = (cnt_q == '0) ? '0 : LEN_W'(cnt_q - 1'b1);
endmodule

// File: rtl/addr_msg_rx.sv
module addr_msg_rx
  import amr_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int LEN_W    = $clog2(MAX_DATA + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            own_addr,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  output logic                  msg_valid,
  output logic [7:0]            msg_cmd,
  output logic [8*MAX_DATA-1:0] msg_data,
  output logic [LEN_W-1:0]      msg_len,
  output logic                  lrc_error
);
  localparam int CNT_W = $clog2(MAX_DATA + 2);

  amr_state_e       state;
  logic             frame_start, byte_acc, byte_cap, chk_pass, chk_fail;
  logic [CNT_W-1:0] body_cnt;
  logic [7:0]       lrc;
  logic             msg_valid_q, lrc_error_q;

  amr_fsm #(.MAX_DATA(MAX_DATA), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .own_addr(own_addr), .body_cnt(body_cnt), .lrc(lrc), .state(state),
    .frame_start(frame_start), .byte_acc(byte_acc), .byte_cap(byte_cap),
    .chk_pass(chk_pass), .chk_fail(chk_fail)
  );

  amr_lrc u_lrc (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .byte_acc(byte_acc), .rx_byte(rx_byte), .lrc(lrc)
  );

  amr_buf #(.MAX_DATA(MAX_DATA), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_cap(byte_cap),
    .rx_byte(rx_byte), .body_cnt(body_cnt), .cmd(msg_cmd),
    .data(msg_data), .len(msg_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid_q <= 1'b0;
      lrc_error_q <= 1'b0;
    end else begin
      msg_valid_q <= chk_pass;
      lrc_error_q <= chk_fail;
    end
  end

  assign msg_valid = msg_valid_q;
  assign lrc_error = lrc_error_q;
endmodule

// File: rtl/amr_chk.sv
module amr_chk
  import amr_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int LEN_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic [7:0]       own_addr,
  input amr_state_e       state,
  input logic             msg_valid,
  input logic             lrc_error,
  input logic [LEN_W-1:0] msg_len
);
  a_r2_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rx_valid && rx_byte != CH_START) |=> state == ST_IDLE);

  a_r3_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && rx_valid && rx_byte != CH_START && rx_byte == own_addr)
      |=> state == ST_BODY);

  a_r3_addr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && rx_valid && rx_byte != CH_START && rx_byte != own_addr)
      |=> state == ST_IDLE);

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE || state == ST_ADDR) && rx_valid && rx_byte == CH_START)
      |=> state == ST_ADDR);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_len <= LEN_W'(MAX_DATA));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && lrc_error));

  a_r9_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHK && rx_valid) |=> state == ST_IDLE);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(state));
endmodule

bind addr_msg_rx amr_chk #(.MAX_DATA(MAX_DATA), .LEN_W(LEN_W)) u_amr_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .own_addr(own_addr), .state(state), .msg_valid(msg_valid),
  .lrc_error(lrc_error), .msg_len(msg_len)
);

// File: tb/addr_msg_rx_bench.sv
module addr_msg_rx_bench;
  localparam int MAX_DATA = 8;
  localparam int LEN_W    = $clog2(MAX_DATA + 1);
  localparam logic [7:0] OWN = 8'h41;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [7:0]            own_addr;
  logic                  rx_valid;
  logic [7:0]            rx_byte;
  logic                  msg_valid;
  logic [7:0]            msg_cmd;
  logic [8*MAX_DATA-1:0] msg_data;
  logic [LEN_W-1:0]      msg_len;
  logic                  lrc_error;

  int checks = 0;
  int errors = 0;
  logic [7:0] fd [MAX_DATA+2];

  always #2 clk = ~clk;

  addr_msg_rx #(.MAX_DATA(MAX_DATA)) u_addr_msg_rx (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .msg_valid(msg_valid), .msg_cmd(msg_cmd),
    .msg_data(msg_data), .msg_len(msg_len), .lrc_error(lrc_error)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] calc_lrc(input logic [7:0] a, input logic [7:0] c, input int n);
    logic [7:0] x = 8'h02 ^ a ^ c ^ 8'h03;
    for (int i = 0; i < n; i++) x ^= fd[i];
    return x;
  endfunction

  task automatic send(input logic [7:0] b, input bit gaps);
    if (gaps) begin
      int g = $urandom % 3;
      for (int k = 0; k < g; k++) begin
        @(negedge clk); rx_valid = 1'b0; rx_byte = 8'($urandom);
      end
    end
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0; rx_byte = 8'($urandom);
  endtask

  task automatic quiet(input string req);
    chk(msg_valid == 1'b0 && lrc_error == 1'b0, req, {msg_valid, lrc_error}, 0);
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input int n,
                            input bit corrupt, input bit gaps, input string req);
    logic [7:0] l = calc_lrc(a, c, n) ^ (corrupt ? 8'h5A : 8'h00);
    bit good = (a == OWN) && !corrupt;
    bit bad  = (a == OWN) && corrupt;
    send(8'h02, gaps); send(a, gaps); send(c, gaps);
    for (int i = 0; i < n; i++) send(fd[i], gaps);
    send(8'h03, gaps);
    send(l, gaps);
    chk(msg_valid == good, req, msg_valid, good);
    chk(lrc_error == bad, "R8", lrc_error, bad);
    if (good) begin
      chk(msg_cmd == c, "R7", msg_cmd, c);
      chk(msg_len == LEN_W'(n), "R7", msg_len, n);
      for (int i = 0; i < n; i++)
        chk(msg_data[8*i +: 8] == fd[i], "R7", msg_data[8*i +: 8], fd[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7031));
    rst_n = 1'b0; own_addr = OWN; rx_valid = 1'b0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_valid == 1'b0, "R1", msg_valid, 0);
    chk(lrc_error == 1'b0, "R1", lrc_error, 0);

    // R2: junk in idle, then a good frame still decodes
    send(8'h41, 0); send(8'h03, 0); send(8'h55, 0); quiet("R2");
    fd[0] = 8'h31; fd[1] = 8'h32;
    send_frame(OWN, 8'h50, 2, 0, 0, "R2");

    // R3: other address dropped
    send_frame(8'h42, 8'h50, 2, 0, 0, "R3");
    send_frame(OWN, 8'h51, 1, 0, 0, "R3");

    // R4: repeated start character restarts the frame and the check
    send(8'h02, 0);
    fd[0] = 8'h7E;
    send_frame(OWN, 8'h20, 1, 0, 0, "R4");

    // R5: non-printable byte aborts silently
    send(8'h02, 0); send(OWN, 0); send(8'h43, 0); send(8'h7F, 0); quiet("R5");
    send(8'h03, 0); send(8'h02 ^ OWN ^ 8'h43 ^ 8'h03, 0); quiet("R5");
    send(8'h41, 0); quiet("R5");
    send_frame(OWN, 8'h44, 0, 0, 0, "R5");

    // R6: empty body aborts
    send(8'h02, 0); send(OWN, 0); send(8'h03, 0); send(8'h02 ^ OWN ^ 8'h03, 0);
    quiet("R6");
    // R6: exact maximum is accepted
    for (int i = 0; i < MAX_DATA; i++) fd[i] = 8'h61 + 8'(i);
    send_frame(OWN, 8'h4D, MAX_DATA, 0, 0, "R6");
    // R6: one byte too many aborts
    begin
      logic [7:0] x = 8'h02 ^ OWN ^ 8'h4D;
      send(8'h02, 0); send(OWN, 0); send(8'h4D, 0);
      for (int i = 0; i < MAX_DATA + 1; i++) begin
        send(8'h61, 0); x ^= 8'h61;
      end
      send(8'h03, 0); send(x ^ 8'h03, 0); quiet("R6");
    end

    // R8: corrupted check
    fd[0] = 8'h39;
    send_frame(OWN, 8'h4B, 1, 1, 0, "R8");

    // R9: back-to-back frames with no gap
    send_frame(OWN, 8'h60, 0, 0, 0, "R9");
    send_frame(OWN, 8'h61, 1, 0, 0, "R9");

    // R10: start characters with rx_valid low are ignored mid-frame
    send(8'h02, 0); send(OWN, 0);
    @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h02;
    @(negedge clk); rx_byte = 8'h00;
    send(8'h70, 0); send(8'h03, 0); send(8'h02 ^ OWN ^ 8'h70 ^ 8'h03, 0);
    chk(msg_valid == 1'b1, "R10", msg_valid, 1);
    chk(msg_cmd == 8'h70, "R10", msg_cmd, 8'h70);

    // random frames with idle gaps
    for (int f = 0; f < 300; f++) begin
      logic [7:0] a, c;
      int n;
      bit corrupt;
      a = ($urandom % 10 < 7) ? OWN : 8'h80 + 8'($urandom % 64);
      c = 8'h20 + 8'($urandom % 95);
      n = $urandom % (MAX_DATA + 1);
      for (int i = 0; i < n; i++) fd[i] = 8'h20 + 8'($urandom % 95);
      corrupt = ($urandom % 5) == 0;
      send_frame(a, c, n, corrupt, 1, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule